// File: doc/BRIEF.md
# Phase-Staggered Multi-Bank Sample Capture

This block records a burst from a set of converter lanes whose clocks share one frequency but are spread evenly across one period. The lanes together form a single full-rate sample stream, but no storage element ever runs at that aggregate rate. Each lane owns a private memory bank and writes it on its own clock edge. A start pulse on the system clock is carried into every lane domain. There it clears that lane's write pointer and opens a capture window that ends once the lane has filled the last address of its bank.

Each lane reports completion back to the system clock through a two-flop synchronizer. Once every lane has reported, the block signals that readout may begin. A consumer then pulls samples one request at a time. The reader visits the banks in lane order and moves to the next row after the last lane. This rebuilds the original time order. The stream is returned with a valid flag and a marker on the final sample.

Top module: `ilv_capture_top`

## Requirements
- R1: After reset, `busy`, `ready`, `rd_valid` and `rd_last` are all low.
- R2: A `start` pulse seen while `busy` is low raises `busy` and drops `ready` in the following cycle. Every lane then begins writing again from address zero, whatever its pointer held before.
- R3: While capturing, each lane writes one sample per cycle of its own clock into its own bank, at consecutive addresses from 0 up to DEPTH-1, and then stops.
- R4: `ready` rises, and `busy` falls, only after the completion of every lane has crossed into the system clock. `ready` then stays high until the next accepted `start`.
- R5: `rd_req` has no effect while `ready` is low, and `rd_valid` stays low.
- R6: Output sample number i (counting from 0 after `ready`) is taken from bank i mod LANES at address i div LANES.
- R7: A request accepted in cycle c yields `rd_valid` high with its data in cycle c+2. Every accepted request yields exactly one valid output.
- R8: `rd_last` is high together with `rd_valid` on sample LANES*DEPTH-1 and on no other sample.
- R9: Requests after the final sample has been accepted are ignored and produce no valid output.
- R10: A `start` pulse while `busy` is high is ignored. The capture in progress completes and reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for every domain |
| sys_clk | input | 1 | System clock for control and readout |
| lane_clk | input | LANES | One capture clock per lane, phase-staggered |
| lane_data | input | LANES*DW | Lane k sample on bits [k*DW +: DW], valid on lane_clk[k] |
| start | input | 1 | One-cycle request to arm a new capture |
| busy | output | 1 | Capture in progress |
| ready | output | 1 | All banks full; readout allowed |
| rd_req | input | 1 | Request the next sample of the rebuilt stream |
| rd_valid | output | 1 | rd_data holds a sample |
| rd_data | output | DW | Time-ordered sample |
| rd_last | output | 1 | Marks the final sample of the capture |

## Verification
The read path has a fixed due time. A request driven before clock edge E appears on `rd_valid`/`rd_data` after edge E+1. The bench therefore keeps a two-deep history of the requests it drove and compares `rd_valid` against the entry from two sampling points back, on every cycle. It also counts those cycles in which no output is expected. `busy` and `ready` are due one edge after the accepted `start` and are sampled at the next falling edge. The end of a capture depends on synchronizer delays across unrelated clocks, so the bench polls `ready` with a bounded wait instead of a fixed count. Lane data carries the lane number and a per-lane sequence, so the order of lanes and of rows can each be checked from the output alone.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Bank that holds aggregate sample idx.
  function automatic int unsigned lane_of(input int unsigned idx, input int unsigned lanes);
    return idx % lanes;
  endfunction

  // Row (bank address) that holds aggregate sample idx.
  function automatic int unsigned row_of(input int unsigned idx, input int unsigned lanes);
    return idx / lanes;
  endfunction

  // Width helper that never returns zero.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ilv_sync2.sv
module ilv_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ilv_lane_bank.sv
module ilv_lane_bank
  import ilv_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = bits_for(DEPTH)
) (
  input  logic          lane_clk,
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          arm_tgl,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  output logic          done_tgl
);
  logic          arm_s;
  logic          arm_seen;
  logic          active;
  logic [AW-1:0] wptr;
  logic [DW-1:0] mem [DEPTH];

  // Arm request crosses into this lane's clock domain.
  ilv_sync2 #(.W(1)) u_arm_sync (
    .clk   (lane_clk),
    .rst_n (rst_n),
    .d     (arm_tgl),
    .q     (arm_s)
  );

  // Named events for the checks below.
  logic arm_evt;
  logic wr_last;
  assign arm_evt = arm_s ^ arm_seen;
  assign wr_last = active && (wptr == AW'(DEPTH - 1));

  always_ff @(posedge lane_clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_seen <= 1'b0;
      active   <= 1'b0;
      wptr     <= '0;
      done_tgl <= 1'b0;
    end else begin
      arm_seen <= arm_s;
      if (arm_evt) begin
        active <= 1'b1;
        wptr   <= '0;
      end else if (active) begin
        if (wr_last) begin
          active   <= 1'b0;
          done_tgl <= arm_seen;
        end else begin
          wptr <= wptr + 1'b1;
        end
      end
    end
  end

  // Write port: lane clock only.
  always_ff @(posedge lane_clk) begin
    if (active) mem[wptr] <= din;
  end

  // Read port: system clock only, used after capture ends.
  always_ff @(posedge sys_clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // R2: an arm event restarts writing from address zero
  p_arm_clears_ptr_r2: assert property (@(posedge lane_clk) disable iff (!rst_n)
    arm_evt |=> (active && wptr == '0));

  // R3: the lane stops after its last address
  p_stop_at_end_r3: assert property (@(posedge lane_clk) disable iff (!rst_n)
    (wr_last && !arm_evt) |=> !active);

  // R3: pointer never moves while idle
  p_idle_hold_r3: assert property (@(posedge lane_clk) disable iff (!rst_n)
    (!active && !arm_evt) |=> $stable(wptr));
endmodule

// File: rtl/ilv_reorder.sv
module ilv_reorder
  import ilv_pkg::*;
#(
  parameter int LANES = 10,
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int TOTAL = LANES * DEPTH,
  localparam int IW    = bits_for(TOTAL),
  localparam int LW    = bits_for(LANES),
  localparam int AW    = bits_for(DEPTH)
) (
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rd_req,
  input  logic [LANES-1:0]    done_s,
  input  logic [LANES*DW-1:0] bank_q,
  output logic                arm_tgl,
  output logic                busy,
  output logic                ready,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                rd_last
);
  logic          drained;
  logic [IW-1:0] idx;
  logic [LW-1:0] lane_c;
  logic [AW-1:0] row_c;
  logic          s1_valid;
  logic          s1_last;
  logic [LW-1:0] s1_lane;

  // Named internal events.
  logic start_ok;
  logic all_back;
  logic cap_done;
  logic accept;
  logic final_acc;
  assign start_ok  = start && !busy;
  assign all_back  = (done_s == {LANES{arm_tgl}});
  assign cap_done  = busy && all_back;
  assign accept    = rd_req && ready && !drained && !start;
  assign final_acc = accept && (idx == IW'(TOTAL - 1));

  assign rd_en   = accept;
  assign rd_addr = row_c;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_tgl  <= 1'b0;
      busy     <= 1'b0;
      ready    <= 1'b0;
      drained  <= 1'b0;
      idx      <= '0;
      lane_c   <= '0;
      row_c    <= '0;
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_lane  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (start_ok) begin
        arm_tgl <= ~arm_tgl;
        busy    <= 1'b1;
        ready   <= 1'b0;
        drained <= 1'b0;
        idx     <= '0;
        lane_c  <= '0;
        row_c   <= '0;
      end else begin
        if (cap_done) begin
          busy  <= 1'b0;
          ready <= 1'b1;
        end
        if (accept) begin
          idx <= idx + 1'b1;
          if (lane_c == LW'(LANES - 1)) begin
            lane_c <= '0;
            row_c  <= row_c + 1'b1;
          end else begin
            lane_c <= lane_c + 1'b1;
          end
          if (final_acc) drained <= 1'b1;
        end
      end
      s1_valid <= accept;
      s1_last  <= final_acc;
      s1_lane  <= lane_c;
      rd_valid <= s1_valid;
      rd_last  <= s1_valid && s1_last;
      if (s1_valid) rd_data <= bank_q[int'(s1_lane)*DW +: DW];
    end
  end

  // R2: accepted start raises busy and drops ready
  p_start_arms_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    start_ok |=> (busy && !ready));

  // R4: ready and busy never overlap
  p_ready_excl_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    busy |-> !ready);

  // R6: counters address bank i mod LANES, row i div LANES
  p_order_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    accept |-> (32'(lane_c) == lane_of(32'(idx), LANES) &&
                32'(row_c)  == row_of(32'(idx), LANES)));

  // R7: output due two cycles after acceptance
  p_latency_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    accept |-> ##2 rd_valid);

  // R8: last only on a valid sample
  p_last_valid_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R10: arm toggle does not move during a capture
  p_arm_hold_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    busy |=> $stable(arm_tgl));

  // R9: after the final acceptance, no further acceptance until restart
  p_no_extra_r9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (final_acc && !start) |=> (!accept || $past(start)));
endmodule

// File: rtl/ilv_capture_top.sv
module ilv_capture_top
  import ilv_pkg::*;
#(
  parameter int LANES = 10,
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = bits_for(DEPTH)
) (
  input  logic                rst_n,
  input  logic                sys_clk,
  input  logic [LANES-1:0]    lane_clk,
  input  logic [LANES*DW-1:0] lane_data,
  input  logic                start,
  output logic                busy,
  output logic                ready,
  input  logic                rd_req,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                rd_last
);
  logic                arm_tgl;
  logic                rd_en;
  logic [AW-1:0]       rd_addr;
  logic [LANES-1:0]    done_tgl;
  logic [LANES-1:0]    done_s;
  logic [LANES*DW-1:0] bank_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ilv_lane_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .lane_clk (lane_clk[k]),
      .sys_clk  (sys_clk),
      .rst_n    (rst_n),
      .arm_tgl  (arm_tgl),
      .din      (lane_data[k*DW +: DW]),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_q     (bank_q[k*DW +: DW]),
      .done_tgl (done_tgl[k])
    );

    ilv_sync2 #(.W(1)) u_done_sync (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .d     (done_tgl[k]),
      .q     (done_s[k])
    );
  end

  ilv_reorder #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_reorder (
    .sys_clk  (sys_clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_req   (rd_req),
    .done_s   (done_s),
    .bank_q   (bank_q),
    .arm_tgl  (arm_tgl),
    .busy     (busy),
    .ready    (ready),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last)
  );

  // R5: no output can start while the banks are not ready
  p_idle_quiet_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |=> !rd_valid || $past(ready, 2));
endmodule

// File: tb/tb_ilv_capture_top.sv
`timescale 1ns/1ps
module tb_ilv_capture_top;
  localparam int LANES = 10;
  localparam int DEPTH = 256;
  localparam int DW    = 8;
  localparam int TOTAL = LANES * DEPTH;
  localparam int NCAP  = 3;
  // Each entry: {data key nibble, idle cycles between requests}
  localparam logic [7:0] CAP_TAB [NCAP] = '{8'h30, 8'hA1, 8'h52};

  logic                rst_n = 1'b0;
  logic                sys_clk = 1'b0;
  logic [LANES-1:0]    lane_clk = '0;
  logic [LANES*DW-1:0] lane_data = '0;
  logic                start = 1'b0;
  logic                rd_req = 1'b0;
  logic                busy, ready, rd_valid, rd_last;
  logic [DW-1:0]       rd_data;

  int  nvec = 0;
  int  nfail = 0;
  bit  finished = 1'b0;
  logic [3:0] key = 4'h0;
  logic [3:0] seq [LANES];
  logic [3:0] base [LANES];

  ilv_capture_top #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) dut (
    .rst_n, .sys_clk, .lane_clk, .lane_data, .start, .busy, .ready,
    .rd_req, .rd_valid, .rd_data, .rd_last
  );

  always #2 sys_clk = ~sys_clk;

  // Lane clocks: 10 ns period, lane k lags lane 0 by k ns.
  // Lane data changes on its falling edge: {lane ^ key, per-lane sequence}.
  initial begin
    int ph;
    ph = 0;
    for (int k = 0; k < LANES; k++) seq[k] = 4'h0;
    forever begin
      #1;
      ph = (ph + 1) % 10;
      for (int k = 0; k < LANES; k++) begin
        lane_clk[k] = (((ph + 10 - k) % 10) < 5);
        if (((ph + 10 - k) % 10) == 5) begin
          seq[k] = seq[k] + 4'h1;
          lane_data[k*DW +: DW] = {4'(k) ^ key, seq[k]};
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n;
    n = 0;
    while (ready !== 1'b1 && n < 5000) begin
      @(negedge sys_clk);
      n++;
    end
    chk(ready === 1'b1 && busy === 1'b0, req, {busy, ready}, 2'b01);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge sys_clk);
    // R1: reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(ready === 1'b0, "R1 ready", ready, 0);
    chk(rd_valid === 1'b0 && rd_last === 1'b0, "R1 rd_valid/rd_last", {rd_valid, rd_last}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);

    // R5: requests before any capture are ignored
    rd_req = 1'b1;
    repeat (4) begin
      @(negedge sys_clk);
      chk(rd_valid === 1'b0, "R5 pre-capture", rd_valid, 0);
    end
    rd_req = 1'b0;

    for (int e = 0; e < NCAP; e++) begin
      int gap, issued, got, cool, tail;
      bit h1, h2, rq;
      key = CAP_TAB[e][7:4];
      gap = int'(CAP_TAB[e][3:0]);
      repeat (12) @(negedge sys_clk);  // let the new key reach every lane
      start = 1'b1;
      @(negedge sys_clk);
      start = 1'b0;
      // R2: busy raised, ready dropped, one edge after start
      chk(busy === 1'b1 && ready === 1'b0, "R2 arm", {busy, ready}, 2'b10);

      if (e == 1) begin
        // R5: requests during capture ignored
        rd_req = 1'b1;
        repeat (4) begin
          @(negedge sys_clk);
          chk(rd_valid === 1'b0, "R5 during capture", rd_valid, 0);
        end
        rd_req = 1'b0;
        repeat (2) begin
          @(negedge sys_clk);
          chk(rd_valid === 1'b0, "R5 during capture", rd_valid, 0);
        end
        // R10: second start while busy, ignored
        repeat (20) @(negedge sys_clk);
        start = 1'b1;
        @(negedge sys_clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy kept", busy, 1);
      end

      wait_ready("R4 ready after all lanes");

      issued = 0; got = 0; cool = 0; tail = 0; h1 = 1'b0; h2 = 1'b0;
      while (tail < 8) begin
        @(negedge sys_clk);
        // R7: output due two sampling points after the request
        chk(rd_valid === h2, (tail > 3) ? "R9 after end" : "R7 latency", rd_valid, h2);
        if (h2 && rd_valid === 1'b1) begin
          int ln, rw;
          ln = got % LANES;
          rw = got / LANES;
          // R6: lane order restored
          chk(rd_data[7:4] === (4'(ln) ^ key), "R6 lane order", rd_data, {4'(ln) ^ key, 4'h0});
          if (rw == 0) base[ln] = rd_data[3:0];
          else
            // R3: consecutive addresses hold consecutive lane samples
            chk(rd_data[3:0] === 4'(base[ln] + 4'(rw)), "R3 row sequence",
                rd_data[3:0], 4'(base[ln] + 4'(rw)));
          // R8: last only on the final sample
          chk(rd_last === (got == TOTAL - 1), "R8 last", rd_last, (got == TOTAL - 1));
          got++;
        end
        h2 = h1;
        rq = 1'b0;
        h1 = 1'b0;
        if (issued < TOTAL) begin
          if (cool == 0) begin
            rq = 1'b1; h1 = 1'b1; issued++; cool = gap;
          end else cool--;
        end else begin
          tail++;
          rq = (tail <= 3);  // R9: extra requests, expected to be ignored
        end
        rd_req = rq;
      end
      rd_req = 1'b0;
      chk(got == TOTAL, "R7 one output per request", got, TOTAL);
      // R4: ready held until the next start
      chk(ready === 1'b1, "R4 ready held", ready, 1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule